// File: doc/BRIEF.md
# Byte-Register Watchdog Timer

This block is a two-stage watchdog. A 6-bit counter steps down once per slow tick. A prescaler makes that tick from the system clock, and its division ratio is a parameter. At the default ratio and a 125 MHz clock, one step lasts 0.6 s, so the remaining time in seconds is the count times 6 / 10. When the count has reached zero, the next tick is an expiry, and the counter reloads from the timeout register.

The first expiry raises a timeout flag, which drives the interrupt output. A second expiry with no kick in between is reported in a second status register. If the no-reboot bit is clear at that moment, the block also requests a system reset for exactly one cycle. Software reaches the block over a synchronous byte bus with single-cycle read latency. Through it, software can:
- halt or run the timer;
- kick the timer;
- read the live count;
- program the timeout;
- clear status flags by writing ones to them;
- hold reboots off with the no-reboot bit until the watchdog has been started.

The sequencing uses three states. `S_HALT` means stopped. `S_COUNT` means running with no expiry pending. `S_WARN` means running after a first expiry.
- `S_HALT` goes to `S_COUNT` once the halt bit reads 0, or to `S_WARN` if an expiry occurs in that cycle.
- `S_COUNT` goes to `S_WARN` on an expiry.
- `S_WARN` goes back to `S_COUNT` on a kick, or on a second expiry, which fires.
- Any state goes to `S_HALT` while the halt bit is 1.

Top module: `wdt_timer`

## Requirements
- R1: After reset the count and timeout register both hold the default 50 (0x32). The control register reads 0x08 (halted), the config register reads 0x02 (no-reboot set), both status registers read 0, and both outputs are low.
- R2: Writing exactly 0x01 to address 0 (the timer) kicks the timer. A kick loads the count from the timeout register, restarts the prescaler and clears any pending first expiry. Any other value written to address 0 has no effect.
- R3: Read data appears on the cycle after the address is presented. Address 0 returns the live count in bits 5:0 with bits 7:6 zero, and unmapped addresses 6 and 7 read 0.
- R4: While running, the count drops by one every TICK_DIV cycles. A tick that finds the count at zero is an expiry, and it reloads the count from the timeout register.
- R5: A write to address 1 stores the value if it lies in 4..63. Any other value stores the default 50. The register reads back in bits 5:0.
- R6: Control register (address 2) bit 3 is the halt bit and reads back as written. While it is 1, the count holds, the prescaler restarts and any pending first expiry is dropped.
- R7: A first expiry sets status-1 (address 3) bit 0, and timeout_irq_o follows that bit. Writing 1 to the bit clears it, and writing 0 leaves it unchanged.
- R8: A second expiry without a kick sets status-2 (address 4) bit 0. If no-reboot is clear at that time, it also sets status-2 bit 1 and pulses sys_reset_req_o high for one cycle.
- R9: Config register (address 5) bit 1 is the no-reboot bit. While it is set, no reset request is ever raised.
- R10: Status-2 bits 1:0 are cleared by writing ones to them. An event that sets a flag in the same cycle wins over the clear.
- R11: After a second expiry, the next expiry counts as a first expiry again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, one cycle after the address |
| timeout_irq_o | output | 1 | Timeout interrupt, level of status-1 bit 0 |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Several properties are checked on every cycle:
- the reset request lasts a single cycle and never follows a cycle with no-reboot set;
- a kick loads the timeout value;
- a halted timer holds its count;
- the timeout register always holds a legal value;
- the interrupt rises only after the count has been at zero.

Some behaviour needs whole scenarios, which the bench runs:
- the two-stage ordering of expiries;
- the restart after a second expiry;
- a kick cancelling a pending warning;
- ones-to-clear against same-cycle setting;
- rejection of out-of-range timeouts.

The bench covers these with directed runs and with random register traffic compared against a cycle model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 6;

    localparam logic [ADDR_W-1:0] A_TMR  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] A_STS1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_STS2 = 3'd4;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd5;

    localparam logic [DATA_W-1:0] KICK_CODE    = 8'h01;
    localparam int                HALT_BIT     = 3;
    localparam int                NOREBOOT_BIT = 1;

    typedef enum logic [1:0] {
        S_HALT  = 2'd0,
        S_COUNT = 2'd1,
        S_WARN  = 2'd2
    } wdt_state_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_DIV = 75_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick_o = run_i && (phase_q == LAST);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (!run_i || restart_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int DEF_LOAD = 50
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             halt_i,
    input  logic             noreboot_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             first_exp_o,
    output logic             second_exp_o,
    output logic             fire_o,
    output logic             rst_req_o
);
    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             expire;
    logic             rst_req_q;

    assign expire = tick_i && (count_q == '0) && !kick_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= S_HALT;
        else         state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (halt_i) begin
            state_d = S_HALT;
        end else begin
            unique case (state_q)
                S_HALT:  state_d = expire ? S_WARN : S_COUNT;
                S_COUNT: if (expire) state_d = S_WARN;
                S_WARN:  if (kick_i || expire) state_d = S_COUNT;
                default: state_d = S_HALT;
            endcase
        end
    end

    // outputs
    always_comb begin
        first_exp_o  = expire && (state_q != S_WARN);
        second_exp_o = expire && (state_q == S_WARN);
        fire_o       = second_exp_o && !noreboot_i;
    end

    // down counter
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= CNT_W'(DEF_LOAD);
        end else if (kick_i) begin
            count_q <= reload_i;
        end else if (tick_i) begin
            count_q <= (count_q == '0) ? reload_i : count_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rst_req_q <= 1'b0;
        else         rst_req_q <= fire_o;
    end

    assign count_o   = count_q;
    assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DEF_LOAD = 50,
    parameter int MIN_LOAD = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              first_exp_i,
    input  logic              second_exp_i,
    input  logic              fire_i,
    output logic [CNT_W-1:0]  reload_o,
    output logic              halt_o,
    output logic              noreboot_o,
    output logic              kick_o,
    output logic              sts1_o
);
    localparam int MAX_LOAD = (1 << CNT_W) - 1;
    localparam int PAD      = DATA_W - CNT_W;

    logic [CNT_W-1:0]  load_q;
    logic              halt_q, nrb_q, sts1_q;
    logic [1:0]        sts2_q;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic              wr_load, wr_ctrl, wr_sts1, wr_sts2, wr_cfg, load_ok;

    always_comb begin
        kick_o  = we_i && (addr_i == A_TMR) && (wdata_i == KICK_CODE);
        wr_load = we_i && (addr_i == A_LOAD);
        wr_ctrl = we_i && (addr_i == A_CTRL);
        wr_sts1 = we_i && (addr_i == A_STS1);
        wr_sts2 = we_i && (addr_i == A_STS2);
        wr_cfg  = we_i && (addr_i == A_CFG);
        load_ok = (int'(wdata_i) >= MIN_LOAD) && (int'(wdata_i) <= MAX_LOAD);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            load_q <= CNT_W'(DEF_LOAD);
            halt_q <= 1'b1;
            nrb_q  <= 1'b1;
            sts1_q <= 1'b0;
            sts2_q <= 2'b00;
        end else begin
            if (wr_load) load_q <= load_ok ? wdata_i[CNT_W-1:0] : CNT_W'(DEF_LOAD);
            if (wr_ctrl) halt_q <= wdata_i[HALT_BIT];
            if (wr_cfg)  nrb_q  <= wdata_i[NOREBOOT_BIT];
            sts1_q <= (sts1_q & ~(wr_sts1 & wdata_i[0])) | first_exp_i;
            sts2_q <= (sts2_q & ~({2{wr_sts2}} & wdata_i[1:0])) | {fire_i, second_exp_i};
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr_i)
            A_TMR:   rd_mux = {{PAD{1'b0}}, count_i};
            A_LOAD:  rd_mux = {{PAD{1'b0}}, load_q};
            A_CTRL:  rd_mux[HALT_BIT] = halt_q;
            A_STS1:  rd_mux[0] = sts1_q;
            A_STS2:  rd_mux[1:0] = sts2_q;
            A_CFG:   rd_mux[NOREBOOT_BIT] = nrb_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rd_mux;
    end

    assign rdata_o    = rdata_q;
    assign reload_o   = load_q;
    assign halt_o     = halt_q;
    assign noreboot_o = nrb_q;
    assign sts1_o     = sts1_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int TICK_DIV = 75_000_000,
    parameter int DEF_LOAD = 50,
    parameter int MIN_LOAD = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              timeout_irq_o,
    output logic              sys_reset_req_o
);
    logic [CNT_W-1:0] count, reload;
    logic             halt_q, noreboot_q, kick, tick;
    logic             first_exp, second_exp, fire, sts1;

    wdt_regs #(.DEF_LOAD(DEF_LOAD), .MIN_LOAD(MIN_LOAD)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .addr_i       (bus_addr_i),
        .we_i         (bus_we_i),
        .wdata_i      (bus_wdata_i),
        .rdata_o      (bus_rdata_o),
        .count_i      (count),
        .first_exp_i  (first_exp),
        .second_exp_i (second_exp),
        .fire_i       (fire),
        .reload_o     (reload),
        .halt_o       (halt_q),
        .noreboot_o   (noreboot_q),
        .kick_o       (kick),
        .sts1_o       (sts1)
    );

    wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (!halt_q),
        .restart_i (kick),
        .tick_o    (tick)
    );

    wdt_fsm #(.DEF_LOAD(DEF_LOAD)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .kick_i       (kick),
        .halt_i       (halt_q),
        .noreboot_i   (noreboot_q),
        .reload_i     (reload),
        .count_o      (count),
        .first_exp_o  (first_exp),
        .second_exp_o (second_exp),
        .fire_o       (fire),
        .rst_req_o    (sys_reset_req_o)
    );

    assign timeout_irq_o = sts1;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
    parameter int MIN_LOAD = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [5:0] count,
    input logic [5:0] reload,
    input logic       halt,
    input logic       noreboot,
    input logic       kick,
    input logic       irq,
    input logic       rst_req
);
    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req |=> !rst_req);

    a_r9_noreboot_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req |-> !$past(noreboot));

    a_r6_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt && !kick) |=> (count == $past(count)));

    a_r2_kick_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick |=> (count == $past(reload)));

    a_r5_legal_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(reload) >= MIN_LOAD);

    a_r7_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq) |-> ($past(count) == 6'd0));
endmodule

bind wdt_timer wdt_timer_chk #(.MIN_LOAD(MIN_LOAD)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .count    (count),
    .reload   (reload),
    .halt     (halt_q),
    .noreboot (noreboot_q),
    .kick     (kick),
    .irq      (timeout_irq_o),
    .rst_req  (sys_reset_req_o)
);

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
    localparam int DIV  = 4;
    localparam int DEF  = 50;
    localparam int MINL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_o;
    logic       irq_o, rst_o;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit chk_on = 0;

    always #4 clk = ~clk;

    wdt_timer #(.TICK_DIV(DIV), .DEF_LOAD(DEF), .MIN_LOAD(MINL)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_o),
        .timeout_irq_o(irq_o), .sys_reset_req_o(rst_o)
    );

    // cycle model built from the requirements
    logic [5:0] m_count, m_load;
    logic       m_halt, m_nrb, m_s1, m_pend, m_rst;
    logic [1:0] m_s2;
    logic [7:0] m_rdata;
    int         m_presc;

    function automatic logic [5:0] legal_load(input logic [7:0] v);
        return (int'(v) >= MINL && int'(v) <= 63) ? v[5:0] : 6'(DEF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count <= 6'(DEF); m_load <= 6'(DEF); m_halt <= 1; m_nrb <= 1;
            m_s1 <= 0; m_s2 <= 0; m_pend <= 0; m_rst <= 0; m_rdata <= 0; m_presc <= 0;
        end else begin
            logic kick, tick, ex, first, second, fire;
            kick   = we && addr == 3'd0 && wdata == 8'h01;
            tick   = !m_halt && m_presc == DIV - 1;
            ex     = tick && m_count == 0 && !kick;
            first  = ex && !m_pend;
            second = ex && m_pend;
            fire   = second && !m_nrb;
            case (addr)
                3'd0: m_rdata <= {2'b0, m_count};
                3'd1: m_rdata <= {2'b0, m_load};
                3'd2: m_rdata <= {4'b0, m_halt, 3'b0};
                3'd3: m_rdata <= {7'b0, m_s1};
                3'd4: m_rdata <= {6'b0, m_s2};
                3'd5: m_rdata <= {6'b0, m_nrb, 1'b0};
                default: m_rdata <= 8'h00;
            endcase
            m_presc <= (m_halt || kick || tick) ? 0 : m_presc + 1;
            if (kick) m_count <= m_load;
            else if (tick) m_count <= (m_count == 0) ? m_load : m_count - 1;
            m_pend <= m_halt ? 1'b0 : kick ? 1'b0 : ex ? !m_pend : m_pend;
            if (we && addr == 3'd1) m_load <= legal_load(wdata);
            if (we && addr == 3'd2) m_halt <= wdata[3];
            if (we && addr == 3'd5) m_nrb <= wdata[1];
            m_s1 <= (m_s1 && !(we && addr == 3'd3 && wdata[0])) || first;
            m_s2 <= (m_s2 & ~((we && addr == 3'd4) ? wdata[1:0] : 2'b00)) | {fire, second};
            m_rst <= fire;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R3 read data", rdata_o, m_rdata);
            chk("R7 irq level", {7'b0, irq_o}, {7'b0, m_s1});
            chk("R8 reset request", {7'b0, rst_o}, {7'b0, m_rst});
            if (rst_o) pulses++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; we = 1'b0;
        @(negedge clk); d = rdata_o;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 2000 && !irq_o; i++) @(negedge clk);
    endtask

    task automatic wait_sts2(output logic [7:0] d);
        d = 0;
        for (int i = 0; i < 1000 && d == 0; i++) rd(3'd4, d);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d, c1;
        int p0;
        void'($urandom(32'd1234));
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; chk_on = 1;

        // R1 reset state
        rd(3'd0, d); chk("R1 count", d, 8'h32);
        rd(3'd1, d); chk("R1 load", d, 8'h32);
        rd(3'd2, d); chk("R1 ctrl", d, 8'h08);
        rd(3'd5, d); chk("R1 cfg", d, 8'h02);
        rd(3'd3, d); chk("R1 sts1", d, 8'h00);
        rd(3'd4, d); chk("R1 sts2", d, 8'h00);
        rd(3'd7, d); chk("R3 unmapped", d, 8'h00);

        // R5 timeout legality
        wr(3'd1, 8'h03); rd(3'd1, d); chk("R5 below range", d, 8'd50);
        wr(3'd1, 8'h40); rd(3'd1, d); chk("R5 above range", d, 8'd50);
        wr(3'd1, 8'd4);  rd(3'd1, d); chk("R5 lower edge", d, 8'd4);
        wr(3'd1, 8'd10); rd(3'd1, d); chk("R5 legal", d, 8'd10);

        // R2 kick while halted, non-kick value ignored
        wr(3'd0, 8'h01); rd(3'd0, d); chk("R2 kick loads", d, 8'd10);
        wr(3'd1, 8'd20); wr(3'd0, 8'h02); rd(3'd0, d); chk("R2 other value ignored", d, 8'd10);
        wr(3'd1, 8'd10);

        // R4 run: after 4*DIV cycles count dropped by 4
        wr(3'd2, 8'h00);
        repeat (4 * DIV) @(negedge clk);
        rd(3'd0, d); chk("R4 decrement", {7'b0, (d < 8'd10)}, 8'h01);

        // R7 first expiry and ones-to-clear
        wait_irq();
        rd(3'd3, d); chk("R7 first expiry flag", d, 8'h01);
        wr(3'd3, 8'h00); rd(3'd3, d); chk("R7 zero write keeps", d, 8'h01);
        wr(3'd3, 8'h01); rd(3'd3, d); chk("R7 one clears", d, 8'h00);

        // R9 second expiry with no-reboot set
        wait_sts2(d); chk("R9 second expiry, no reset", d, 8'h01);
        chk("R9 no pulses", 8'(pulses), 8'h00);

        // R11 restart after second expiry
        wr(3'd4, 8'h03);
        wait_irq();
        rd(3'd4, d); chk("R11 next is first", d, 8'h00);

        // R2 kick drops the pending warning
        wr(3'd0, 8'h01); wr(3'd3, 8'h01);
        wait_irq();
        rd(3'd4, d); chk("R2 kick clears pending", d, 8'h00);

        // R8 reset request with no-reboot clear
        p0 = pulses;
        wr(3'd5, 8'h00);
        wait_sts2(d); chk("R8 both flags", d, 8'h03);
        repeat (3) @(negedge clk);
        chk("R8 one pulse", 8'(pulses - p0), 8'h01);
        wr(3'd4, 8'h03); rd(3'd4, d); chk("R10 clear", d, 8'h00);

        // R6 halt holds count
        wr(3'd2, 8'h08); rd(3'd2, d); chk("R6 readback", d, 8'h08);
        rd(3'd0, c1);
        repeat (40) @(negedge clk);
        rd(3'd0, d); chk("R6 count held", d, c1);

        // random traffic against the model
        wr(3'd1, 8'd5); wr(3'd2, 8'h00);
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [7:0] v;
            int r;
            a = 3'($urandom_range(0, 7));
            r = $urandom_range(0, 9);
            case (a)
                3'd0: v = (r < 7) ? 8'h01 : 8'($urandom_range(0, 255));
                3'd1: v = 8'($urandom_range(0, 70));
                3'd2: v = (r < 8) ? 8'h00 : 8'h08;
                3'd5: v = (r < 6) ? 8'h00 : 8'h02;
                default: v = 8'($urandom_range(0, 255));
            endcase
            if ($urandom_range(0, 3) == 0) wr(a, v);
            else rd(a, d);
            repeat ($urandom_range(0, 6)) @(negedge clk);
        end
        @(negedge clk);
        finish_run();
    end
endmodule